// File: doc/BRIEF.md
# Reshapeable Dual-Port Block RAM Tile

A 20,480-bit synchronous RAM tile whose word shape is fixed at elaboration time. The storage is 1024 physical rows of 20 bits. A narrow shape packs several words into a row, and the low address bits pick the slice. The 40-bit and 33-bit shapes pair two adjacent rows into one word. In dual-port operation, both ports can read and write. In two-port operation, port A only writes and port B only reads. This is the only operation that allows the wide shapes.

Each port chooses one of three behaviours for its registered output during a write. The output can keep its value, show the data being written, or show the word that the write replaces. The 33-bit shape stores each word with seven check bits. A port B read corrects a single flipped bit and raises a flag. A read with two flipped bits raises a second flag and returns the stored data unchanged. A parameter supplies the contents that every row takes while reset is held.

Top module: `bram_tile`

## Requirements
- R1: `DATA_W` selects the shape. It is 1, 2, 5, 10 or 20 in either operation, and 40 or 33 only when `TWO_PORT` is 1. Narrow shapes hold 16, 8, 4, 2 or 1 words per row. Element `a` lives in row `a / words-per-row`, at bits `[(a % words-per-row)*DATA_W +: DATA_W]`. Writing one element leaves every other element of the same row unchanged.
- R2: While `rstN` is low, outputs and flags are 0 and each even row is loaded with `INIT_PAIR[19:0]` and each odd row with `INIT_PAIR[39:20]`. A wide word `k` is `{row 2k+1, row 2k}`.
- R3: Reads are synchronous. When a port does not write, its output shows the word at the address sampled on the previous rising edge.
- R4: In dual-port operation, a write with mode code 0 (and also the unused code 3) leaves that port's output unchanged.
- R5: A write with mode code 1 puts the written data on that port's output after the same edge.
- R6: A write with mode code 2 puts the word's contents from before the write on that port's output.
- R7: In dual-port operation, both ports work in the same cycle on different addresses. A read sees the value from before any same-cycle write, and a write by one port is visible to the other port from the next cycle.
- R8: In two-port operation, `doutA` stays 0 and the write inputs of port B have no effect on the memory.
- R9: In the 33-bit shape, a word written through port A reads back unchanged on port B with both flags low.
- R10: The 33-bit word is stored as 40 bits. Bit 0 is overall even parity. Bit p (1 to 39) is Hamming position p. Check bits sit at positions 1, 2, 4, 8, 16 and 32, and the data bits fill the remaining positions in ascending order. A single flipped bit is corrected on `doutB` and `eccSingle` is raised with the data.
- R11: When the syndrome is non-zero and the overall parity is even, `eccDouble` is raised and `doutB` carries the stored data bits uncorrected.
- R12: `eccSingle` and `eccDouble` are never high together, and both stay 0 in every shape other than 33-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rstN | input | 1 | Active-low synchronous reset and preset |
| weA | input | 1 | Port A write enable |
| modeA | input | 2 | Port A output behaviour on write (0 hold, 1 new data, 2 old data) |
| addrA | input | AW | Port A word address |
| dinA | input | DATA_W | Port A write data |
| doutA | output | DATA_W | Port A registered read data |
| weB | input | 1 | Port B write enable (ignored in two-port operation) |
| modeB | input | 2 | Port B output behaviour on write |
| addrB | input | AW | Port B word address |
| dinB | input | DATA_W | Port B write data |
| doutB | output | DATA_W | Port B registered read data |
| eccSingle | output | 1 | Corrected single-bit error on the last port B read |
| eccDouble | output | 1 | Uncorrectable error on the last port B read |

## Verification
A wrong slice select or row index corrupts a neighbouring element silently. It shows at the ports only when that neighbour is next read, which is one cycle after the read address is applied. That is why the bench reads both sides of every slice boundary that it writes. A wrong write-mode decode shows on the output one cycle after the write, as a held, new or old value where another was expected. A codeword bit placed at the wrong position shows on the first read of a preset word: a preset single error reads back either uncorrected or flagged as double.

// File: rtl/bram_pkg.sv
package bram_pkg;
  localparam int ROWS  = 1024;
  localparam int ROW_W = 20;

  typedef enum logic [1:0] {
    WR_SIMPLE = 2'd0,
    WR_FEED   = 2'd1,
    WR_RBW    = 2'd2,
    WR_SPARE  = 2'd3
  } wrMode_e;

  // Per-port strobes from control to datapath
  typedef struct packed {
    logic wr;       // store the incoming word
    logic takeOld;  // output loads the addressed (pre-write) contents
    logic takeNew;  // output loads the incoming data
    logic zero;     // output forced to zero
  } portCtl_t;

  function automatic int slicesFor(int w);
    case (w)
      1:       return 16;
      2:       return 8;
      5:       return 4;
      10:      return 2;
      default: return 1;
    endcase
  endfunction

  function automatic int depthFor(int w);
    return (w > ROW_W) ? ROWS / 2 : ROWS * slicesFor(w);
  endfunction

  // bit 0 overall parity, bit p = Hamming position p
  function automatic logic [39:0] eccEncode(logic [32:0] d);
    logic [39:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < 40; p++) begin
      if ((p & (p - 1)) != 0) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int j = 0; j < 6; j++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p < 40; p++)
        if ((p & (1 << j)) != 0) par ^= cw[p];
      cw[1 << j] = par;
    end
    cw[0] = ^cw[39:1];
    return cw;
  endfunction

  // returns {double, single, data}
  function automatic logic [34:0] eccDecode(logic [39:0] cw);
    logic [5:0]  syn;
    logic [39:0] fixedCw;
    logic [32:0] d;
    logic        sbe, dbe;
    int k;
    syn = '0;
    for (int p = 1; p < 40; p++)
      if (cw[p]) syn ^= 6'(p);
    fixedCw = cw;
    sbe = 1'b0;
    dbe = 1'b0;
    if (^cw) begin
      if (syn > 6'd39) dbe = 1'b1;
      else begin
        sbe = 1'b1;
        fixedCw[syn] = ~fixedCw[syn];
      end
    end else if (syn != 6'd0) begin
      dbe = 1'b1;
    end
    k = 0;
    d = '0;
    for (int p = 1; p < 40; p++) begin
      if ((p & (p - 1)) != 0) begin
        d[k] = fixedCw[p];
        k++;
      end
    end
    return {dbe, sbe, d};
  endfunction
endpackage

// File: rtl/bram_control.sv
module bram_control
  import bram_pkg::*;
#(
  parameter bit TWO_PORT = 1'b0
) (
  input  logic     weA,
  input  wrMode_e  modeA,
  input  logic     weB,
  input  wrMode_e  modeB,
  output portCtl_t ctlA,
  output portCtl_t ctlB
);

  function automatic portCtl_t decodePort(logic we, wrMode_e m);
    portCtl_t c;
    c    = '0;
    c.wr = we;
    if (!we) c.takeOld = 1'b1;
    else begin
      case (m)
        WR_FEED: c.takeNew = 1'b1;
        WR_RBW:  c.takeOld = 1'b1;
        default: ;
      endcase
    end
    return c;
  endfunction

  always_comb begin
    if (TWO_PORT) begin
      ctlA = '{wr: weA, takeOld: 1'b0, takeNew: 1'b0, zero: 1'b1};
      ctlB = '{wr: 1'b0, takeOld: 1'b1, takeNew: 1'b0, zero: 1'b0};
    end else begin
      ctlA = decodePort(weA, modeA);
      ctlB = decodePort(weB, modeB);
    end
  end

endmodule

// File: rtl/bram_datapath.sv
module bram_datapath
  import bram_pkg::*;
#(
  parameter int          DATA_W    = 20,
  parameter int          AW        = 10,
  parameter logic [39:0] INIT_PAIR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  portCtl_t          ctlA,
  input  portCtl_t          ctlB,
  input  logic [AW-1:0]     addrA,
  input  logic [AW-1:0]     addrB,
  input  logic [DATA_W-1:0] dinA,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutA,
  output logic [DATA_W-1:0] doutB,
  output logic              eccSingle,
  output logic              eccDouble
);

  localparam bit ECC    = (DATA_W == 33);
  localparam bit WIDE   = (DATA_W > ROW_W);
  localparam int PW     = ECC ? 40 : DATA_W;
  localparam int SLICES = slicesFor(DATA_W);
  localparam int SELW   = $clog2(SLICES);
  localparam int RW     = $clog2(ROWS);

  logic [ROW_W-1:0]  mem [ROWS];
  logic [PW-1:0]     wordA, wordB, oldA, oldB;
  logic [DATA_W-1:0] viewA, viewB;
  logic              sbeB, dbeB;

  // Storage coding
  if (ECC) begin : g_ecc
    logic [34:0] decB;
    assign wordA = eccEncode(dinA);
    assign wordB = eccEncode(dinB);
    assign viewA = 33'(eccDecode(oldA));
    assign decB  = eccDecode(oldB);
    assign viewB = decB[32:0];
    assign sbeB  = decB[33];
    assign dbeB  = decB[34];
  end else begin : g_plain
    assign wordA = dinA;
    assign wordB = dinB;
    assign viewA = oldA;
    assign viewB = oldB;
    assign sbeB  = 1'b0;
    assign dbeB  = 1'b0;
  end

  // Address mapping onto physical rows
  if (WIDE) begin : g_wide
    logic [RW-1:0] rowA, rowB;
    assign rowA = {addrA, 1'b0};
    assign rowB = {addrB, 1'b0};
    assign oldA = {mem[rowA | RW'(1)], mem[rowA]};
    assign oldB = {mem[rowB | RW'(1)], mem[rowB]};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < ROWS; r++)
          mem[r] <= r[0] ? INIT_PAIR[39:20] : INIT_PAIR[19:0];
      end else begin
        if (ctlA.wr) begin
          mem[rowA | RW'(1)] <= wordA[39:20];
          mem[rowA]          <= wordA[19:0];
        end
        if (ctlB.wr) begin
          mem[rowB | RW'(1)] <= wordB[39:20];
          mem[rowB]          <= wordB[19:0];
        end
      end
    end
  end else begin : g_narrow
    logic [RW-1:0] rowA, rowB;
    int selA, selB;
    assign rowA = RW'(addrA >> SELW);
    assign rowB = RW'(addrB >> SELW);
    assign selA = int'(addrA) & (SLICES - 1);
    assign selB = int'(addrB) & (SLICES - 1);
    assign oldA = mem[rowA][selA*PW +: PW];
    assign oldB = mem[rowB][selB*PW +: PW];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int r = 0; r < ROWS; r++)
          mem[r] <= r[0] ? INIT_PAIR[39:20] : INIT_PAIR[19:0];
      end else begin
        if (ctlA.wr) mem[rowA][selA*PW +: PW] <= wordA;
        if (ctlB.wr) mem[rowB][selB*PW +: PW] <= wordB;
      end
    end
  end

  // Output registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutA     <= '0;
      doutB     <= '0;
      eccSingle <= 1'b0;
      eccDouble <= 1'b0;
    end else begin
      if (ctlA.zero)         doutA <= '0;
      else if (ctlA.takeOld) doutA <= viewA;
      else if (ctlA.takeNew) doutA <= dinA;
      if (ctlB.zero)         doutB <= '0;
      else if (ctlB.takeOld) doutB <= viewB;
      else if (ctlB.takeNew) doutB <= dinB;
      eccSingle <= ctlB.takeOld & sbeB;
      eccDouble <= ctlB.takeOld & dbeB;
    end
  end

endmodule

// File: rtl/bram_tile.sv
module bram_tile
  import bram_pkg::*;
#(
  parameter int          DATA_W    = 20,
  parameter bit          TWO_PORT  = 1'b0,
  parameter logic [39:0] INIT_PAIR = '0,
  localparam int         AW        = $clog2(depthFor(DATA_W))
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              weA,
  input  logic [1:0]        modeA,
  input  logic [AW-1:0]     addrA,
  input  logic [DATA_W-1:0] dinA,
  output logic [DATA_W-1:0] doutA,
  input  logic              weB,
  input  logic [1:0]        modeB,
  input  logic [AW-1:0]     addrB,
  input  logic [DATA_W-1:0] dinB,
  output logic [DATA_W-1:0] doutB,
  output logic              eccSingle,
  output logic              eccDouble
);

  portCtl_t ctlA, ctlB;

  bram_control #(.TWO_PORT(TWO_PORT)) ctrl (
    .weA  (weA),
    .modeA(wrMode_e'(modeA)),
    .weB  (weB),
    .modeB(wrMode_e'(modeB)),
    .ctlA (ctlA),
    .ctlB (ctlB)
  );

  bram_datapath #(.DATA_W(DATA_W), .AW(AW), .INIT_PAIR(INIT_PAIR)) dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctlA     (ctlA),
    .ctlB     (ctlB),
    .addrA    (addrA),
    .addrB    (addrB),
    .dinA     (dinA),
    .dinB     (dinB),
    .doutA    (doutA),
    .doutB    (doutB),
    .eccSingle(eccSingle),
    .eccDouble(eccDouble)
  );

endmodule

// File: rtl/bram_tile_checker.sv
module bram_tile_checker #(
  parameter int DATA_W   = 20,
  parameter bit TWO_PORT = 1'b0,
  parameter int AW       = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              weA,
  input logic [1:0]        modeA,
  input logic [AW-1:0]     addrA,
  input logic [DATA_W-1:0] dinA,
  input logic [DATA_W-1:0] doutA,
  input logic              weB,
  input logic [1:0]        modeB,
  input logic [AW-1:0]     addrB,
  input logic [DATA_W-1:0] dinB,
  input logic [DATA_W-1:0] doutB,
  input logic              eccSingle,
  input logic              eccDouble
);

  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(eccSingle && eccDouble));

  assert_flags_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    (DATA_W != 33) |-> (!eccSingle && !eccDouble));

  assert_write_only_R8: assert property (@(posedge clk) disable iff (!rstN)
    TWO_PORT |-> (doutA == '0));

  assert_simple_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!TWO_PORT && weA && modeA != 2'd1 && modeA != 2'd2) |=> $stable(doutA));

  assert_feed_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!TWO_PORT && weA && modeA == 2'd1) |=> (doutA == $past(dinA)));

  assert_feed_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!TWO_PORT && weB && modeB == 2'd1) |=> (doutB == $past(dinB)));

  assert_readback_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!TWO_PORT && weA && !(weB && addrB == addrA)) ##1 (!weA && addrA == $past(addrA))
    |=> (doutA == $past(dinA, 2)));

  assert_ecc_roundtrip_R9: assert property (@(posedge clk) disable iff (!rstN)
    (TWO_PORT && DATA_W == 33 && weA) ##1 (addrB == $past(addrA))
    |=> (doutB == $past(dinA, 2) && !eccSingle && !eccDouble));

endmodule

bind bram_tile bram_tile_checker #(.DATA_W(DATA_W), .TWO_PORT(TWO_PORT), .AW(AW)) chk (.*);

// File: tb/bram_tile_test.sv
`timescale 1ns/1ps
module bram_tile_test;
  localparam int          W     = 5;
  localparam int          AW    = 12;
  localparam int          DEPTH = 4096;
  localparam logic [39:0] INIT  = 40'hA5C3E_1B2D4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  // dual-port x5 instance
  logic          weA = 0, weB = 0;
  logic [1:0]    modeA = 0, modeB = 0;
  logic [AW-1:0] addrA = 0, addrB = 0;
  logic [W-1:0]  dinA = 0, dinB = 0, doutA, doutB;
  logic          sbe0, dbe0;

  bram_tile #(.DATA_W(W), .TWO_PORT(1'b0), .INIT_PAIR(INIT)) uut (
    .clk(clk), .rstN(rstN), .weA(weA), .modeA(modeA), .addrA(addrA), .dinA(dinA),
    .doutA(doutA), .weB(weB), .modeB(modeB), .addrB(addrB), .dinB(dinB),
    .doutB(doutB), .eccSingle(sbe0), .eccDouble(dbe0));

  // two-port 33-bit instances, preset with one and two flipped bits
  logic        eWeA = 0, eWeB = 0;
  logic [1:0]  eModeA = 0, eModeB = 0;
  logic [8:0]  eAddrA = 0, eAddrB = 0;
  logic [32:0] eDinA = 0, eDinB = 0;
  logic [32:0] e1DoutA, e1DoutB, e2DoutA, e2DoutB;
  logic        e1Sbe, e1Dbe, e2Sbe, e2Dbe;

  bram_tile #(.DATA_W(33), .TWO_PORT(1'b1), .INIT_PAIR(40'h8)) uutEcc1 (
    .clk(clk), .rstN(rstN), .weA(eWeA), .modeA(eModeA), .addrA(eAddrA), .dinA(eDinA),
    .doutA(e1DoutA), .weB(eWeB), .modeB(eModeB), .addrB(eAddrB), .dinB(eDinB),
    .doutB(e1DoutB), .eccSingle(e1Sbe), .eccDouble(e1Dbe));

  bram_tile #(.DATA_W(33), .TWO_PORT(1'b1), .INIT_PAIR(40'h18)) uutEcc2 (
    .clk(clk), .rstN(rstN), .weA(eWeA), .modeA(eModeA), .addrA(eAddrA), .dinA(eDinA),
    .doutA(e2DoutA), .weB(eWeB), .modeB(eModeB), .addrB(eAddrB), .dinB(eDinB),
    .doutB(e2DoutB), .eccSingle(e2Sbe), .eccDouble(e2Dbe));

  int checks = 0;
  int errors = 0;
  string curReq = "R2";
  logic [W-1:0] refMem [DEPTH];
  logic [W-1:0] expA = 0, expB = 0;

  function automatic logic [W-1:0] initVal(int a);
    int row, sel;
    logic [19:0] rv;
    row = a >> 2;
    sel = a & 3;
    rv  = row[0] ? INIT[39:20] : INIT[19:0];
    return rv[sel*W +: W];
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock: update the reference from the inputs seen at the edge, then compare
  task automatic step();
    logic [W-1:0] oa, ob;
    @(posedge clk);
    #1;
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) refMem[a] = initVal(a);
      expA = '0;
      expB = '0;
    end else begin
      oa = refMem[addrA];
      ob = refMem[addrB];
      if (!weA || modeA == 2'd2) expA = oa;
      else if (modeA == 2'd1)   expA = dinA;
      if (!weB || modeB == 2'd2) expB = ob;
      else if (modeB == 2'd1)   expB = dinB;
      if (weA) refMem[addrA] = dinA;
      if (weB) refMem[addrB] = dinB;
    end
    check({curReq, " port A"}, 64'(doutA), 64'(expA));
    check({curReq, " port B"}, 64'(doutB), 64'(expB));
    check("R12 flags quiet", {62'b0, sbe0, dbe0}, 64'b0);
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R2: reset state
    curReq = "R2 reset";
    repeat (3) step();
    check("R2 ecc flags at reset", {60'b0, e1Sbe, e1Dbe, e2Sbe, e2Dbe}, 64'b0);
    rstN = 1'b1;

    // R2 / R3: preset contents read back one cycle after the address
    curReq = "R2 R3 preset read";
    eAddrB = 9'd5;
    for (int i = 0; i < 8; i++) begin
      addrA = AW'(i);
      addrB = AW'(DEPTH - 1 - i);
      step();
    end

    // R10 / R11: preset words carry one and two flipped bits
    check("R10 corrected data", 64'(e1DoutB), 64'd0);
    check("R10 single flag", {62'b0, e1Sbe, e1Dbe}, 64'b10);
    check("R11 raw data", 64'(e2DoutB), 64'd1);
    check("R11 double flag", {62'b0, e2Sbe, e2Dbe}, 64'b01);

    // R1 / R7: neighbouring slices of one row written by both ports
    curReq = "R1 R7 slice write";
    weA = 1; addrA = 12'd4; dinA = 5'h1F; modeA = 2'd0;
    weB = 1; addrB = 12'd5; dinB = 5'h0A; modeB = 2'd0;
    step();
    weA = 0; weB = 0;
    curReq = "R1 slice readback";
    addrA = 12'd4; addrB = 12'd5; step();
    addrA = 12'd6; addrB = 12'd7; step();
    addrA = 12'd3; addrB = 12'd8; step();

    // R7: cross-port visibility and read of pre-write value
    curReq = "R7 cross port";
    weA = 1; addrA = 12'd100; dinA = 5'h13; addrB = 12'd100; step();
    weA = 0; step();

    // R4: hold during write, codes 0 and 3
    curReq = "R4 hold";
    addrA = 12'd20; step();
    weA = 1; modeA = 2'd0; dinA = 5'h07; step();
    modeA = 2'd3; addrA = 12'd21; dinA = 5'h19; step();
    weA = 0; addrA = 12'd20; step();
    addrA = 12'd21; step();

    // R5 / R6 on port B
    curReq = "R5 feed";
    weB = 1; modeB = 2'd1; addrB = 12'd30; dinB = 5'h15; step();
    curReq = "R6 old data";
    modeB = 2'd2; dinB = 5'h02; step();
    weB = 0; step();
    curReq = "R6 port A old data";
    weA = 1; modeA = 2'd2; addrA = 12'd30; dinA = 5'h11; step();
    weA = 0; step();

    // R7: mixed traffic on both ports
    curReq = "R7 traffic";
    for (int n = 0; n < 400; n++) begin
      weA   = 1'($urandom);
      weB   = 1'($urandom);
      modeA = 2'($urandom);
      modeB = 2'($urandom);
      addrA = AW'($urandom % 64);
      addrB = AW'($urandom % 64);
      dinA  = W'($urandom);
      dinB  = W'($urandom);
      if (weA && weB && addrA == addrB) weB = 1'b0;
      step();
    end
    weA = 0; weB = 0;

    // R8 / R9: two-port 33-bit write through A, read on B
    curReq = "R3 idle";
    eWeA = 1; eModeA = 2'd1; eAddrA = 9'd7; eDinA = 33'h1_2345_6789; step();
    check("R8 port A stays zero", 64'(e1DoutA), 64'd0);
    eWeA = 0; eAddrB = 9'd7; step();
    check("R9 readback data", 64'(e1DoutB), 64'h1_2345_6789);
    check("R9 flags clear", {62'b0, e1Sbe, e1Dbe}, 64'b0);
    check("R9 readback second tile", 64'(e2DoutB), 64'h1_2345_6789);
    check("R8 port A stays zero", 64'(e2DoutA), 64'd0);

    // R8: port B write inputs ignored
    eWeB = 1; eModeB = 2'd1; eAddrB = 9'd9; eDinB = 33'h0_FFFF_FFFF; step();
    eWeB = 0; step();
    check("R8 port B write ignored", 64'(e1DoutB), 64'd0);
    check("R8 preset word intact", {62'b0, e1Sbe, e1Dbe}, 64'b10);
    check("R11 preset word intact", {62'b0, e2Sbe, e2Dbe}, 64'b01);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule